// File: doc/BRIEF.md
# Correlator Write Recovery Wait-State Controller

This block sits between a simple synchronous host bus and a slow correlator register bank. The bank takes a fixed time to absorb each write internally. The controller lowers its ready output whenever a correlator access arrives while that absorption time, called the recovery window, is still running. The window is converted to clock cycles from a clock period and two window times given as parameters. One window time is for real-input operation and the other is for complex-input operation.

Accesses to the peripheral region never wait and never start a window. A write to the high-half staging address only loads an internal byte. A later write to either low-half increment address (carrier or code) combines the staged high byte with its own data, issues the commit and starts the window.

The host holds a request with its fields stable until it sees ready high at a rising clock edge. That edge accepts the access. From that edge the block drives a one-cycle forwarded strobe, the registered address and data, and a commit pulse for the bank.

Top module: `corr_wait_ctrl`

## Requirements
- R1: After reset, ready_o is high, wr_stb_o, rd_stb_o and commit_o are low, and the staged high byte is zero.
- R2: A committing correlator write accepted at edge E holds off every later correlator access, staging writes included, until edge E+N+2. N is ceil(REAL_PS/CLK_PS) in real-input mode, which is 38 with the defaults.
- R3: When cplx_i is high at the window start, N is ceil(CPLX_PS/CLK_PS), which is 40 with the defaults.
- R4: The mode is sampled once, at the edge where the write strobe falls (E+1). Changing cplx_i after that edge does not alter the running window.
- R5: Peripheral accesses (corr_sel_i low) see ready_o high at all times, never start a window, and never change the staged byte.
- R6: A correlator write to STAGE_ADDR (0x70) stores its data as the high byte, produces no commit pulse and starts no window.
- R7: A correlator write to CARR_LO_ADDR (0x71) or CODE_LO_ADDR (0x72) pulses commit_o, drives commit_data_o = {high byte, write data}, and starts a window.
- R8: A low-half write with no preceding staging write uses the last staged high byte, or zero if nothing has been staged since reset.
- R9: A correlator read waits out an active window and starts no window of its own, so back-to-back reads are accepted on consecutive edges.
- R10: Any other correlator write pulses commit_o with commit_data_o = {8'h00, write data} and starts a window.
- R11: In the cycle after acceptance, exactly one of wr_stb_o and rd_stb_o is high for one cycle. addr_o, wdata_o and corr_sel_o carry the accepted access during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access request, held until accepted |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Host address |
| wdata_i | input | DW | Host write data |
| corr_sel_i | input | 1 | 1 = correlator region, 0 = peripheral region |
| cplx_i | input | 1 | 1 = complex-input mode, 0 = real-input mode |
| ready_o | output | 1 | Low while a correlator access is held off |
| wr_stb_o | output | 1 | Forwarded one-cycle write strobe |
| rd_stb_o | output | 1 | Forwarded one-cycle read strobe |
| addr_o | output | AW | Address of the forwarded access |
| wdata_o | output | DW | Data of the forwarded write |
| corr_sel_o | output | 1 | Region of the forwarded access |
| commit_o | output | 1 | Bank commit pulse |
| commit_data_o | output | 2*DW | Commit value, high byte then low byte |

## Verification
Back-to-back correlator writes in each mode measure the exact acceptance gap. The gap tells a window of 38 cycles apart from one of 40, and shows whether the mode is taken at the strobe's falling edge or later.

Peripheral accesses and reads are placed inside open windows. They separate the region and direction gating from the plain hold-off.

Staging writes followed by a low-half write, and low-half writes without a prior staging write, show whether the high byte is combined, kept across commits, or cleared. They also show that a staging write itself starts no window.

// File: rtl/corr_wait_pkg.sv
package corr_wait_pkg;

  typedef enum logic [1:0] {
    ACC_PLAIN = 2'd0,
    ACC_STAGE = 2'd1,
    ACC_LOW   = 2'd2
  } acc_kind_e;

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/corr_addr_decode.sv
module corr_addr_decode
  import corr_wait_pkg::*;
#(
  parameter int unsigned AW         = 8,
  parameter int unsigned NUM_LO     = 2,
  parameter logic [AW-1:0] STAGE_ADDR = 8'h70,
  parameter logic [NUM_LO*AW-1:0] LO_ADDRS = 16'h7271
) (
  input  logic [AW-1:0] addr_i,
  output acc_kind_e     kind_o
);

  logic [NUM_LO-1:0] lo_hit;

  for (genvar g = 0; g < NUM_LO; g++) begin : g_lo
    assign lo_hit[g] = (addr_i == LO_ADDRS[g*AW +: AW]);
  end

  always_comb begin
    if (addr_i == STAGE_ADDR) kind_o = ACC_STAGE;
    else if (|lo_hit)         kind_o = ACC_LOW;
    else                      kind_o = ACC_PLAIN;
  end

endmodule

// File: rtl/corr_recovery_timer.sv
module corr_recovery_timer #(
  parameter int unsigned CW    = 6,
  parameter int unsigned WIN_R = 38,
  parameter int unsigned WIN_C = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic cplx_i,
  output logic busy_o
);

  localparam logic [CW-1:0] LEN_R = CW'(WIN_R);
  localparam logic [CW-1:0] LEN_C = CW'(WIN_C);

  logic          pend_q;
  logic [CW-1:0] cnt_q;

  // pend covers the strobe cycle; the window is loaded when the strobe falls
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= start_i;
      if (pend_q)           cnt_q <= cplx_i ? LEN_C : LEN_R;
      else if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
    end
  end

  assign busy_o = pend_q | (cnt_q != '0);

  p_start_when_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);

  p_count_down_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/corr_hi_stage.sv
module corr_hi_stage #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] hi_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_o <= '0;
    else if (load_i) hi_o <= data_i;
  end

endmodule

// File: rtl/corr_wait_ctrl.sv
module corr_wait_ctrl
  import corr_wait_pkg::*;
#(
  parameter int unsigned AW           = 8,
  parameter int unsigned DW           = 8,
  parameter int unsigned CLK_PS       = 8000,
  parameter int unsigned REAL_PS      = 300000,
  parameter int unsigned CPLX_PS      = 314000,
  parameter logic [AW-1:0] STAGE_ADDR   = 8'h70,
  parameter logic [AW-1:0] CARR_LO_ADDR = 8'h71,
  parameter logic [AW-1:0] CODE_LO_ADDR = 8'h72
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            corr_sel_i,
  input  logic            cplx_i,
  output logic            ready_o,
  output logic            wr_stb_o,
  output logic            rd_stb_o,
  output logic [AW-1:0]   addr_o,
  output logic [DW-1:0]   wdata_o,
  output logic            corr_sel_o,
  output logic            commit_o,
  output logic [2*DW-1:0] commit_data_o
);

  localparam int unsigned WIN_R  = ceil_div(REAL_PS, CLK_PS);
  localparam int unsigned WIN_C  = ceil_div(CPLX_PS, CLK_PS);
  localparam int unsigned WIN_MX = (WIN_R > WIN_C) ? WIN_R : WIN_C;
  localparam int unsigned CW     = $clog2(WIN_MX + 1);
  localparam int unsigned NUM_LO = 2;
  localparam logic [NUM_LO*AW-1:0] LO_LIST = {CODE_LO_ADDR, CARR_LO_ADDR};

  acc_kind_e     kind;
  logic          busy;
  logic          acc;
  logic          commit_now;
  logic          stage_now;
  logic [DW-1:0] hi_byte;

  corr_addr_decode #(
    .AW(AW), .NUM_LO(NUM_LO), .STAGE_ADDR(STAGE_ADDR), .LO_ADDRS(LO_LIST)
  ) u_dec (
    .addr_i (addr_i),
    .kind_o (kind)
  );

  corr_recovery_timer #(.CW(CW), .WIN_R(WIN_R), .WIN_C(WIN_C)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (commit_now),
    .cplx_i  (cplx_i),
    .busy_o  (busy)
  );

  corr_hi_stage #(.DW(DW)) u_stage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (stage_now),
    .data_i (wdata_i),
    .hi_o   (hi_byte)
  );

  assign ready_o    = ~(req_i & corr_sel_i & busy);
  assign acc        = req_i & ready_o;
  assign stage_now  = acc & we_i & corr_sel_i & (kind == ACC_STAGE);
  assign commit_now = acc & we_i & corr_sel_i & (kind != ACC_STAGE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_stb_o      <= 1'b0;
      rd_stb_o      <= 1'b0;
      commit_o      <= 1'b0;
      addr_o        <= '0;
      wdata_o       <= '0;
      corr_sel_o    <= 1'b0;
      commit_data_o <= '0;
    end else begin
      wr_stb_o <= acc & we_i;
      rd_stb_o <= acc & ~we_i;
      commit_o <= commit_now;
      if (acc) begin
        addr_o     <= addr_i;
        wdata_o    <= wdata_i;
        corr_sel_o <= corr_sel_i;
      end
      if (commit_now)
        commit_data_o <= (kind == ACC_LOW) ? {hi_byte, wdata_i} : {{DW{1'b0}}, wdata_i};
    end
  end

  p_peri_no_wait_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !corr_sel_i) |-> ready_o);

  p_commit_outside_window_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> !$past(busy));

  p_commit_is_corr_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> (wr_stb_o && corr_sel_o));

  p_stage_no_commit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_o && corr_sel_o && addr_o == STAGE_ADDR) |-> !commit_o);

  p_strobe_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_stb_o && rd_stb_o));

endmodule

// File: tb/corr_wait_ctrl_tb.sv
`timescale 1ns/1ps
module corr_wait_ctrl_tb;

  localparam int NR = (300000 + 8000 - 1) / 8000;  // 38
  localparam int NC = (314000 + 8000 - 1) / 8000;  // 40
  localparam logic [7:0] A_STG = 8'h70;
  localparam logic [7:0] A_CAR = 8'h71;
  localparam logic [7:0] A_COD = 8'h72;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0, corr_sel_i = 1'b0, cplx_i = 1'b0;
  logic [7:0] addr_i = '0, wdata_i = '0;
  logic ready_o, wr_stb_o, rd_stb_o, corr_sel_o, commit_o;
  logic [7:0] addr_o, wdata_o;
  logic [15:0] commit_data_o;

  corr_wait_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .corr_sel_i(corr_sel_i), .cplx_i(cplx_i), .ready_o(ready_o),
    .wr_stb_o(wr_stb_o), .rd_stb_o(rd_stb_o), .addr_o(addr_o), .wdata_o(wdata_o),
    .corr_sel_o(corr_sel_o), .commit_o(commit_o), .commit_data_o(commit_data_o)
  );

  always #4 clk_i = ~clk_i;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // reference model state
  int m_cnt = 0;
  bit m_pend = 0, m_wr = 0, m_rd = 0, m_commit = 0, m_corr = 0;
  logic [7:0] m_hi = 0, m_addr = 0, m_data = 0;
  logic [15:0] m_cdata = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  task automatic cycle(input bit rq, input bit we, input bit corr, input logic [7:0] a,
                       input logic [7:0] d, input bit cx, input string tag, output bit acc);
    bit m_ready;
    @(negedge clk_i);
    check(wr_stb_o == m_wr, "R11 wr_stb", wr_stb_o, m_wr);
    check(rd_stb_o == m_rd, "R11 rd_stb", rd_stb_o, m_rd);
    if (m_wr || m_rd) begin
      check(addr_o == m_addr, "R11 addr", addr_o, m_addr);
      check(corr_sel_o == m_corr, "R11 corr_sel", corr_sel_o, m_corr);
      if (m_wr) check(wdata_o == m_data, "R11 wdata", wdata_o, m_data);
    end
    check(commit_o == m_commit, "R6 R7 R10 commit", commit_o, m_commit);
    if (m_commit) check(commit_data_o == m_cdata, "R7 R8 R10 commit_data", commit_data_o, m_cdata);
    req_i = rq; we_i = we; corr_sel_i = corr; addr_i = a; wdata_i = d; cplx_i = cx;
    #1;
    m_ready = !(rq && corr && (m_pend || m_cnt > 0));
    check(ready_o == m_ready, tag, ready_o, m_ready);
    acc = rq && m_ready;
    if (m_pend) begin m_cnt = cx ? NC : NR; m_pend = 0; end
    else if (m_cnt > 0) m_cnt--;
    m_wr = acc && we; m_rd = acc && !we; m_commit = 0;
    if (acc) begin
      m_addr = a; m_data = d; m_corr = corr;
      if (we && corr) begin
        if (a == A_STG) m_hi = d;
        else begin
          m_commit = 1;
          m_cdata = (a == A_CAR || a == A_COD) ? {m_hi, d} : {8'h00, d};
          m_pend = 1;
        end
      end
    end
    cyc++;
  endtask

  task automatic op(input bit we, input bit corr, input logic [7:0] a, input logic [7:0] d,
                    input bit cx, input string tag, output int at);
    bit acc;
    acc = 0;
    while (!acc) cycle(1'b1, we, corr, a, d, cx, tag, acc);
    at = cyc;
  endtask

  task automatic idle(input int n, input bit cx);
    bit acc;
    for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, 1'b0, 8'h00, 8'h00, cx, "R2 idle", acc);
  endtask

  int t0, t1, t2, t3;

  initial begin
    repeat (3) @(negedge clk_i);
    check(ready_o == 1'b1, "R1 ready", ready_o, 1);
    check(wr_stb_o == 1'b0 && rd_stb_o == 1'b0, "R1 strobes", {wr_stb_o, rd_stb_o}, 0);
    check(commit_o == 1'b0, "R1 commit", commit_o, 0);
    rst_ni = 1'b1;

    // R8: low-half write with nothing staged since reset -> high byte zero
    op(1, 1, A_CAR, 8'h5A, 0, "R8 low no stage", t0);
    // R2 R10: plain correlator write waits the real window
    op(1, 1, 8'h10, 8'hC3, 0, "R2 R10 second write", t1);
    check(t1 - t0 == NR + 2, "R2 gap real", t1 - t0, NR + 2);

    // R5 peripheral inside window; R9 read waits, then reads are back to back
    op(1, 0, 8'h20, 8'h11, 0, "R5 peripheral write", t2);
    check(t2 - t1 == 1, "R5 gap", t2 - t1, 1);
    op(0, 0, 8'h21, 8'h00, 0, "R5 peripheral read", t3);
    check(t3 - t2 == 1, "R5 read gap", t3 - t2, 1);
    op(0, 1, 8'h12, 8'h00, 0, "R9 read in window", t2);
    check(t2 - t1 == NR + 2, "R9 read held", t2 - t1, NR + 2);
    op(0, 1, 8'h13, 8'h00, 0, "R9 back to back read", t3);
    check(t3 - t2 == 1, "R9 read no window", t3 - t2, 1);

    // R3: complex mode window
    op(1, 1, 8'h14, 8'h22, 1, "R3 write", t0);
    op(1, 1, 8'h15, 8'h33, 1, "R3 write", t1);
    check(t1 - t0 == NC + 2, "R3 gap complex", t1 - t0, NC + 2);

    // R4: mode taken when the strobe falls
    idle(NC + 3, 0);
    op(1, 1, 8'h16, 8'h44, 0, "R4 write", t0);
    op(1, 1, 8'h17, 8'h55, 1, "R4 write", t1);
    check(t1 - t0 == NC + 2, "R4 gap real->cplx", t1 - t0, NC + 2);
    op(1, 1, 8'h18, 8'h66, 0, "R4 write", t2);
    check(t2 - t1 == NR + 2, "R4 gap cplx->real", t2 - t1, NR + 2);

    // R6 R7: staging then low-half commit
    idle(NC + 3, 0);
    op(1, 1, A_STG, 8'hA5, 0, "R6 stage", t0);
    op(1, 1, A_COD, 8'h3C, 0, "R6 R7 low after stage", t1);
    check(t1 - t0 == 1, "R6 stage no window", t1 - t0, 1);
    op(1, 1, A_STG, 8'h7E, 0, "R2 stage waits", t2);
    check(t2 - t1 == NR + 2, "R2 stage held", t2 - t1, NR + 2);
    op(0, 1, 8'h19, 8'h00, 0, "R6 read after stage", t3);
    check(t3 - t2 == 1, "R6 read after stage gap", t3 - t2, 1);
    op(1, 1, A_CAR, 8'h01, 0, "R7 carrier low", t0);
    // R8: staged byte kept across commits
    op(1, 1, A_COD, 8'h02, 0, "R8 reuse staged", t1);
    // R5: peripheral write to the staging address leaves the staged byte alone
    op(1, 0, A_STG, 8'hFF, 0, "R5 peripheral stage addr", t2);
    op(1, 1, A_CAR, 8'h03, 0, "R5 R8 low after peripheral", t3);
    idle(NC + 3, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule